// File: doc/BRIEF.md
# Four-Channel DMA Controller with Burst, Cycle-Stealing and Transparent Modes

This block moves words between peripherals and a shared system memory on behalf of the processor. Each of its four channels has a memory address register, a word count register and a control register that the CPU loads over a small register port. A peripheral raises its request line when it has a word to move. The controller then asks the CPU for the bus with a hold request. Once the hold is acknowledged, it acknowledges the winning channel and drives the memory address with a read or write strobe for one clock per word.

A channel's control register selects one of three modes. Burst mode keeps the bus until the whole block is moved. Cycle-stealing mode takes the bus for a single word and then hands it back. Transparent mode never asks for the bus: it moves a word only in a cycle in which the CPU signals that the bus is idle. When a channel's count runs out, its completion flag is set and an interrupt is raised. The channel then stays masked until the CPU enables it again.

Top module: `dmac_top`

## Requirements
- R1: When several enabled channels request at the same time, only the lowest-numbered one is served first, and at most one `dev_ack` bit is high in any cycle.
- R2: The CPU port reaches register `cpu_addr[1:0]` of channel `cpu_addr[3:2]`, where 0 is the address, 1 is the count and 2 is control (bit 0 enable, bit 1 direction, bits 3:2 mode). Written values read back on `cpu_rdata`, and all registers read zero after reset.
- R3: When the direction bit is 1, a word moves from the device to memory and `mem_wr` pulses. When it is 0, a word moves from memory to the device and `mem_rd` pulses. The two strobes are never high together.
- R4: Outside transparent mode, no strobe and no `dev_ack` appear until `hold_ack` answers `hold_req`. The acknowledge and the strobe share the same cycle.
- R5: A count of N moves exactly N+1 words. The last word sets the channel's bit in the status register (`cpu_addr[1:0]`=3, bit = channel), raises `irq`, and clears the channel's enable bit. Reading the status register clears all of its bits and drops `irq`.
- R6: In burst mode (mode 0), the words of a block go out on consecutive cycles, whatever the request line does, until the count is exhausted.
- R7: In cycle-stealing mode (mode 1, and code 3), each grant moves one word, and `hold_req` is low in the cycle after that word. After the last word of a burst, `hold_req` is also low in the next cycle.
- R8: In transparent mode (mode 2), `hold_req` stays low, and a word moves only in a cycle with `bus_idle` high.
- R9: After each word, the channel's address increases by one and its count decreases by one, while the count is not zero.
- R10: CPU writes to the address, count or control register of the channel being served, from its grant until its release, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe; reading status clears it |
| cpu_addr | input | 4 | {channel, register select} |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data (combinational) |
| dev_req | input | 4 | Per-channel peripheral request |
| dev_ack | output | 4 | Per-channel acknowledge, high during the word cycle |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | CPU grants the bus |
| bus_idle | input | 1 | CPU is not using the bus this cycle |
| mem_addr | output | 16 | Memory address of the current word |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| irq | output | 1 | Completion interrupt, high while any status bit is set |

## Verification
The checker takes for granted that the CPU, once it has raised `hold_ack`, keeps it high for as long as `hold_req` stays high. It also assumes that `hold_ack` is low whenever `hold_req` has been low at the preceding edge. The bench's CPU model grants after a random latency of one to three cycles and withdraws the grant as soon as the request falls, which keeps within both assumptions. Peripherals hold their request until they see their acknowledge, then drop it for at least a cycle. `bus_idle` is driven at random, independently of everything else.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic [1:0] {
      MODE_BURST  = 2'd0,
      MODE_STEAL  = 2'd1,
      MODE_TRANSP = 2'd2
   } xfer_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_HOLD,
      SQ_XFER,
      SQ_TWAIT
   } seq_state_e;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_CTL  = 2'd2;
   localparam logic [1:0] SEL_STAT = 2'd3;

   function automatic xfer_mode_e decode_mode(input logic [1:0] code);
      case (code)
         2'd0:    return MODE_BURST;
         2'd2:    return MODE_TRANSP;
         default: return MODE_STEAL;
      endcase
   endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_addr,
   input  logic          wr_cnt,
   input  logic          wr_ctl,
   input  logic [DW-1:0] wdata,
   input  logic          word_done,
   input  logic          tc_clr,
   output logic [AW-1:0] addr_q,
   output logic [CW-1:0] cnt_q,
   output logic          en_q,
   output logic          dir_q,
   output xfer_mode_e    mode_q,
   output logic          tc_q,
   output logic          last
);
   assign last = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         en_q   <= 1'b0;
         dir_q  <= 1'b0;
         mode_q <= MODE_BURST;
      end else if (word_done) begin
         addr_q <= addr_q + 1'b1;
         if (last) en_q  <= 1'b0;
         else      cnt_q <= cnt_q - 1'b1;
      end else begin
         if (wr_addr) addr_q <= wdata[AW-1:0];
         if (wr_cnt)  cnt_q  <= wdata[CW-1:0];
         if (wr_ctl) begin
            en_q   <= wdata[0];
            dir_q  <= wdata[1];
            mode_q <= decode_mode(wdata[3:2]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tc_q <= 1'b0;
      else if (word_done && last) tc_q <= 1'b1;
      else if (tc_clr)            tc_q <= 1'b0;
   end
endmodule

// File: rtl/dmac_prio_arb.sv
module dmac_prio_arb #(
   parameter int N = 4
) (
   input  logic [N-1:0]         req,
   output logic                 valid,
   output logic [$clog2(N)-1:0] idx
);
   localparam int W = $clog2(N);

   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            valid = 1'b1;
            idx   = W'(i);
         end
      end
   end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
   import dmac_pkg::*;
#(
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pick_valid,
   input  logic [CH_W-1:0] pick_idx,
   input  xfer_mode_e      pick_mode,
   input  logic            cur_last,
   input  logic            hold_ack,
   input  logic            bus_idle,
   output logic [CH_W-1:0] cur_idx,
   output logic            busy,
   output logic            hold_req,
   output logic            strobe
);
   seq_state_e st;
   xfer_mode_e mode_r;

   assign busy     = (st != SQ_IDLE);
   assign hold_req = (st == SQ_HOLD) || (st == SQ_XFER);
   assign strobe   = (st == SQ_XFER) || ((st == SQ_TWAIT) && bus_idle);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         cur_idx <= '0;
         mode_r  <= MODE_BURST;
      end else begin
         case (st)
            SQ_IDLE: if (pick_valid) begin
               cur_idx <= pick_idx;
               mode_r  <= pick_mode;
               st      <= (pick_mode == MODE_TRANSP) ? SQ_TWAIT : SQ_HOLD;
            end
            SQ_HOLD:  if (hold_ack) st <= SQ_XFER;
            SQ_XFER:  if (mode_r != MODE_BURST || cur_last) st <= SQ_IDLE;
            SQ_TWAIT: if (bus_idle) st <= SQ_IDLE;
            default:  st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dmac_top.sv
module dmac_top
   import dmac_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 16,
   parameter int CW  = 16,
   parameter int DW  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_we,
   input  logic                      cpu_re,
   input  logic [$clog2(NCH)+1:0]    cpu_addr,
   input  logic [DW-1:0]             cpu_wdata,
   output logic [DW-1:0]             cpu_rdata,
   input  logic [NCH-1:0]            dev_req,
   output logic [NCH-1:0]            dev_ack,
   output logic                      hold_req,
   input  logic                      hold_ack,
   input  logic                      bus_idle,
   output logic [AW-1:0]             mem_addr,
   output logic                      mem_rd,
   output logic                      mem_wr,
   output logic                      irq
);
   localparam int CH_W = $clog2(NCH);

   if (NCH < 2)            begin : g_bad_nch $error("NCH must be at least 2"); end
   if (AW > DW || CW > DW) begin : g_bad_w   $error("AW and CW must fit in DW"); end
   if (NCH > DW)           begin : g_bad_st  $error("status needs NCH <= DW"); end
   if (DW < 4)             begin : g_bad_dw  $error("control needs DW >= 4"); end

   logic [CH_W-1:0] ch_f;
   logic [1:0]      sel;
   assign ch_f = cpu_addr[CH_W+1:2];
   assign sel  = cpu_addr[1:0];

   logic [AW-1:0] addr_a [NCH];
   logic [CW-1:0] cnt_a  [NCH];
   xfer_mode_e    mode_a [NCH];
   logic [NCH-1:0] en_v, dir_v, tc_v, last_v, elig_v;

   logic            busy, strobe, pick_valid;
   logic [CH_W-1:0] cur_idx, pick_idx;
   logic            tc_clr;

   assign tc_clr = cpu_re && (sel == SEL_STAT);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit, active;
      assign active = busy && (cur_idx == CH_W'(i));
      assign hit    = cpu_we && (ch_f == CH_W'(i)) && !active;
      assign elig_v[i]  = dev_req[i] && en_v[i];
      assign dev_ack[i] = strobe && (cur_idx == CH_W'(i));

      dmac_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_addr   (hit && (sel == SEL_ADDR)),
         .wr_cnt    (hit && (sel == SEL_CNT)),
         .wr_ctl    (hit && (sel == SEL_CTL)),
         .wdata     (cpu_wdata),
         .word_done (dev_ack[i]),
         .tc_clr    (tc_clr),
         .addr_q    (addr_a[i]),
         .cnt_q     (cnt_a[i]),
         .en_q      (en_v[i]),
         .dir_q     (dir_v[i]),
         .mode_q    (mode_a[i]),
         .tc_q      (tc_v[i]),
         .last      (last_v[i])
      );
   end

   dmac_prio_arb #(.N(NCH)) u_arb (
      .req   (elig_v),
      .valid (pick_valid),
      .idx   (pick_idx)
   );

   dmac_seq #(.CH_W(CH_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pick_valid (pick_valid),
      .pick_idx   (pick_idx),
      .pick_mode  (mode_a[pick_idx]),
      .cur_last   (last_v[cur_idx]),
      .hold_ack   (hold_ack),
      .bus_idle   (bus_idle),
      .cur_idx    (cur_idx),
      .busy       (busy),
      .hold_req   (hold_req),
      .strobe     (strobe)
   );

   assign mem_addr = addr_a[cur_idx];
   assign mem_wr   = strobe &&  dir_v[cur_idx];
   assign mem_rd   = strobe && !dir_v[cur_idx];
   assign irq      = |tc_v;

   always_comb begin
      case (sel)
         SEL_ADDR: cpu_rdata = DW'(addr_a[ch_f]);
         SEL_CNT:  cpu_rdata = DW'(cnt_a[ch_f]);
         SEL_CTL:  cpu_rdata = DW'({mode_a[ch_f], dir_v[ch_f], en_v[ch_f]});
         default:  cpu_rdata = DW'(tc_v);
      endcase
   end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
   parameter int NCH = 4,
   parameter int AW  = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] dev_ack,
   input logic           hold_req,
   input logic           hold_ack,
   input logic           bus_idle,
   input logic [AW-1:0]  mem_addr,
   input logic           mem_rd,
   input logic           mem_wr,
   input logic           irq
);
   p_single_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_ack));

   p_rdwr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_strobe_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && hold_req) |-> hold_ack);

   p_transp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !hold_req) |-> bus_idle);

   p_irq_after_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mem_rd || mem_wr));

   p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && hold_req && $past(mem_rd || mem_wr))
         |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));
endmodule

bind dmac_top dmac_chk #(.NCH(NCH), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dev_ack  (dev_ack),
   .hold_req (hold_req),
   .hold_ack (hold_ack),
   .bus_idle (bus_idle),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .irq      (irq)
);

// File: tb/dmac_top_bench.sv
`timescale 1ns/100ps
module dmac_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0, cpu_re = 1'b0;
   logic [3:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic [3:0]  dev_req = '0;
   logic [3:0]  dev_ack;
   logic        hold_req, hold_ack = 1'b0, bus_idle = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, irq;

   always #2.5 clk = ~clk;

   dmac_top u_dmac_top (.*);

   int checks = 0, errors = 0, cyc = 0;

   // bench-side model
   int   m_addr [4];
   int   m_cnt  [4];
   int   m_left [4];
   int   m_mode [4];
   bit   m_dir  [4];
   bit   m_act  [4];
   bit [3:0] m_tc = '0;
   bit [3:0] arm = '0, rearm = '0, auto_r = '0, ack_seen = '0;
   bit   hold_gate = 1'b1, rnd_idle = 1'b0;
   int   hcnt = 0, hlat = 0;
   bit   exp_cont = 0, exp_drop = 0;
   int   cont_ch = 0;
   int   logq [64];
   int   log_n = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ack_idx(input logic [3:0] a);
      for (int i = 0; i < 4; i++) if (a[i]) return i;
      return -1;
   endfunction

   function automatic bit any_left();
      for (int i = 0; i < 4; i++) if (m_left[i] > 0) return 1'b1;
      return 1'b0;
   endfunction

   // CPU hold model, peripheral model and idle driver: posedge + 1 ns
   always @(posedge clk) begin
      #1;
      cyc++;
      if (!hold_req) begin
         hold_ack = 1'b0; hcnt = 0; hlat = $urandom_range(0, 2);
      end else if (hold_gate && !hold_ack) begin
         if (hcnt >= hlat) hold_ack = 1'b1;
         else hcnt++;
      end
      for (int c = 0; c < 4; c++) begin
         if (ack_seen[c]) begin
            dev_req[c] = 1'b0; ack_seen[c] = 1'b0; rearm[c] = auto_r[c];
         end else if (arm[c] || rearm[c]) begin
            dev_req[c] = 1'b1; arm[c] = 1'b0; rearm[c] = 1'b0;
         end
      end
      if (rnd_idle) bus_idle = $urandom_range(0, 1);
   end

   // monitor / scoreboard: negedge
   always @(negedge clk) begin
      if (rst_n) begin
         bit s;
         int c;
         s = mem_rd || mem_wr;
         c = ack_idx(dev_ack);
         if (exp_cont) chk(s && c == cont_ch, "R6", "burst continues", c, cont_ch);
         if (exp_drop) chk(!hold_req, "R7", "hold released", hold_req, 0);
         exp_cont = 0; exp_drop = 0;
         if (s) begin
            chk($countones(dev_ack) == 1, "R1", "one ack per word", $countones(dev_ack), 1);
            if (c >= 0) begin
               chk(m_act[c] && m_left[c] > 0, "R5", "word allowed", m_left[c], 1);
               chk(mem_addr == m_addr[c][15:0], "R9", "word address", mem_addr, m_addr[c]);
               chk(mem_wr == m_dir[c], "R3", "direction", mem_wr, m_dir[c]);
               if (m_mode[c] == 2)
                  chk(bus_idle && !hold_req, "R8", "transparent word", {bus_idle, hold_req}, 2);
               else
                  chk(hold_req && hold_ack, "R4", "word under hold", {hold_req, hold_ack}, 3);
               if (log_n < 64) logq[log_n] = c;
               log_n++;
               ack_seen[c] = 1'b1;
               m_addr[c] = (m_addr[c] + 1) & 16'hFFFF;
               m_left[c]--;
               if (m_left[c] <= 0) begin
                  m_left[c] = 0; m_tc[c] = 1'b1; m_act[c] = 1'b0; m_cnt[c] = 0;
               end else begin
                  m_cnt[c]--;
               end
               if (m_mode[c] == 0 && m_left[c] > 0) begin
                  exp_cont = 1; cont_ch = c;
               end else if (m_mode[c] != 2) begin
                  exp_drop = 1;
               end
            end
         end
      end
   end

   // watchdog
   always @(negedge clk) begin
      if (cyc > 150000) begin
         chk(1'b0, "WD", "watchdog expired", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wr_reg(input int ch, input int sel, input int val);
      @(posedge clk); #1;
      cpu_we = 1'b1; cpu_addr = 4'(ch * 4 + sel); cpu_wdata = 16'(val);
      @(posedge clk); #1;
      cpu_we = 1'b0;
   endtask

   task automatic rd_reg(input int ch, input int sel, output int val);
      @(posedge clk); #1;
      cpu_re = 1'b1; cpu_addr = 4'(ch * 4 + sel);
      @(negedge clk);
      val = cpu_rdata;
      @(posedge clk); #1;
      cpu_re = 1'b0;
   endtask

   // program a channel and update the model; mode: 0 burst, 1 steal, 2 transparent
   task automatic setup(input int ch, input int addr, input int cnt,
                        input int mode, input bit dir);
      wr_reg(ch, 0, addr);
      wr_reg(ch, 1, cnt);
      m_addr[ch] = addr; m_cnt[ch] = cnt; m_mode[ch] = mode; m_dir[ch] = dir;
      m_left[ch] = cnt + 1; m_act[ch] = 1'b1;
      wr_reg(ch, 2, (mode << 2) | (int'(dir) << 1) | 1);
   endtask

   task automatic wait_done();
      while (any_left()) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic check_status(input string req);
      int v;
      chk(irq == (m_tc != 0), req, "irq level", irq, m_tc != 0);
      rd_reg(0, 3, v);
      chk(v == m_tc, req, "status bits", v, m_tc);
      m_tc = '0;
      @(negedge clk);
      chk(irq == 1'b0, req, "irq cleared by read", irq, 0);
   endtask

   initial begin
      int v;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) begin
         m_addr[i] = 0; m_cnt[i] = 0; m_left[i] = 0; m_mode[i] = 0;
         m_dir[i] = 0; m_act[i] = 0;
      end
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // reset state (R2)
      chk(!hold_req && dev_ack == 0 && !irq && !mem_rd && !mem_wr, "R2", "reset outputs",
          {hold_req, dev_ack, irq}, 0);
      rd_reg(2, 0, v); chk(v == 0, "R2", "reset address reg", v, 0);
      rd_reg(2, 2, v); chk(v == 0, "R2", "reset control reg", v, 0);

      // register access (R2)
      wr_reg(2, 0, 16'hA5C3); rd_reg(2, 0, v); chk(v == 16'hA5C3, "R2", "address readback", v, 16'hA5C3);
      wr_reg(2, 1, 16'h0102); rd_reg(2, 1, v); chk(v == 16'h0102, "R2", "count readback", v, 16'h0102);
      wr_reg(2, 2, 16'h0006); rd_reg(2, 2, v); chk(v == 6, "R2", "control readback", v, 6);
      wr_reg(2, 2, 0);

      // priority (R1): channels 3, 1, 2 request together, one word each
      setup(1, 16'h1000, 0, 1, 1'b1);
      setup(2, 16'h2000, 0, 1, 1'b0);
      setup(3, 16'h3000, 0, 1, 1'b1);
      log_n = 0;
      arm = 4'b1110;
      wait_done();
      chk(log_n == 3, "R1", "words served", log_n, 3);
      chk(logq[0] == 1, "R1", "first served", logq[0], 1);
      chk(logq[1] == 2, "R1", "second served", logq[1], 2);
      chk(logq[2] == 3, "R1", "third served", logq[2], 3);
      rd_reg(1, 0, v); chk(v == 16'h1001, "R9", "address advanced", v, 16'h1001);
      rd_reg(3, 1, v); chk(v == 0, "R9", "count at zero", v, 0);
      rd_reg(1, 2, v); chk(v[0] == 1'b0, "R5", "enable cleared at end", v[0], 0);
      check_status("R5");

      // burst (R6) with wrap of the address
      setup(0, 16'hFFFD, 4, 0, 1'b0);
      arm[0] = 1'b1;
      wait_done();
      rd_reg(0, 0, v); chk(v == 16'h0002, "R9", "burst address wrap", v, 2);
      check_status("R5");

      // writes to the active channel are ignored (R10)
      hold_gate = 1'b0;
      setup(0, 16'h0400, 3, 0, 1'b1);
      arm[0] = 1'b1;
      while (!hold_req) @(negedge clk);
      chk(dev_ack == 0 && !mem_wr, "R4", "no word before grant", dev_ack, 0);
      wr_reg(0, 0, 16'hBEEF);
      wr_reg(0, 1, 9);
      wr_reg(0, 2, 0);
      rd_reg(0, 0, v); chk(v == 16'h0400, "R10", "address write ignored", v, 16'h0400);
      rd_reg(0, 1, v); chk(v == 3, "R10", "count write ignored", v, 3);
      rd_reg(0, 2, v); chk(v == 3, "R10", "control write ignored", v, 3);
      chk(dev_ack == 0, "R4", "still waiting for grant", dev_ack, 0);
      hold_gate = 1'b1;
      wait_done();
      check_status("R5");

      // steal (R7) and transparent (R8) with streaming peripherals
      rnd_idle = 1'b1;
      auto_r = 4'b1100;
      setup(2, 16'h0800, 3, 1, 1'b1);
      setup(3, 16'h0900, 2, 2, 1'b0);
      arm = 4'b1100;
      wait_done();
      check_status("R5");
      // channels finished but requests keep coming: must stay masked (R5)
      repeat (20) @(negedge clk);
      chk(dev_ack == 0 && !hold_req, "R5", "masked after completion", dev_ack, 0);
      auto_r = '0;
      repeat (4) @(negedge clk);

      // constrained random rounds
      for (int r = 0; r < 12; r++) begin
         bit [3:0] use_m;
         use_m = 4'($urandom_range(1, 15));
         for (int c = 0; c < 4; c++) begin
            if (use_m[c]) begin
               int md;
               md = $urandom_range(0, 2);
               setup(c, $urandom_range(0, 16'hFFFF), $urandom_range(0, 6), md,
                     1'($urandom_range(0, 1)));
               auto_r[c] = (md != 0);
            end
         end
         arm = use_m;
         wait_done();
         auto_r = '0;
         repeat (3) @(negedge clk);
         check_status("R5");
      end
      rnd_idle = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule